// File: doc/BRIEF.md
# Receive Destination Address Filter

The block watches the first six bytes of a received frame after the start-of-frame delimiter and decides whether the frame is kept. It checks three things about those bytes. It tests whether they equal a programmed 48-bit station address. It tests whether they are the all-ones broadcast address. It also tests whether they carry the group (multicast) flag. For multicast it takes six bits of the running frame CRC, which an external CRC unit presents once the last address byte has gone through it. Those six bits select one bit of a 64-bit hash table. Three control inputs steer the decision: accept everything, allow hashed multicast, and allow broadcast.

The station address and the hash table are loaded a byte at a time through plain write ports. A frame starts with a one-cycle start pulse. The address bytes then arrive with a valid strobe, and the CRC snapshot arrives with its own strobe. One cycle after the snapshot is taken, the block gives a single decision pulse. With that pulse come an accept flag and a code saying which rule matched.

Top module: `rx_addr_filter`

## Requirements
- R1: When all six received address bytes equal the station address, the decision reports accept with match code 1 (unicast). Station byte k is compared with the k-th byte after the frame start, where byte k is write index k and bits [8k+7:8k] of the address.
- R2: If even one address byte differs from the station address, the frame is not classed as unicast. With every other rule failing, the decision reports reject with match code 0.
- R3: An address whose first byte has bit 0 set is a multicast address. It is accepted with match code 2 when multicast is enabled and the table bit chosen by the hash index is 1. If that table bit is 0, it is rejected.
- R4: When multicast enable is low, a non-broadcast multicast address is never accepted through the table.
- R5: The all-ones address is accepted with match code 3 (broadcast) when broadcast enable is high.
- R6: With broadcast enable low, the all-ones address is still accepted with match code 3 when multicast is enabled and its hashed table bit is 1.
- R7: In promiscuous mode, a frame that no other rule accepts is accepted with match code 4.
- R8: Rule priority is unicast, then broadcast, then multicast, then promiscuous. The reported code is the first rule that matches.
- R9: The decision pulse is high for exactly one cycle. That cycle comes one cycle after the clock edge where the snapshot strobe is seen with all six bytes taken. There is at most one pulse per frame. Outside the pulse, accept is 0 and the match code is 0.
- R10: Bytes after the sixth do not change the decision. A snapshot strobe seen before the sixth byte is ignored.
- R11: After reset, and until a start pulse, no decision is made. A start pulse drops any partly collected address and begins a new frame.
- R12: The hash index is CRC snapshot bits [31:26]. A table write of data D at index k sets table bits [8k+7:8k] to D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sta_wr_en | input | 1 | Write strobe for one station address byte |
| sta_wr_idx | input | 3 | Station address byte number (0 = first byte on the wire) |
| sta_wr_data | input | 8 | Station address byte value |
| tbl_wr_en | input | 1 | Write strobe for one hash table byte |
| tbl_wr_idx | input | 3 | Hash table byte number |
| tbl_wr_data | input | 8 | Hash table byte value (bit j is table bit 8*idx+j) |
| ctl_promisc | input | 1 | Accept every frame |
| ctl_mcast_en | input | 1 | Allow multicast acceptance through the hash table |
| ctl_bcast_en | input | 1 | Allow broadcast acceptance |
| frm_start | input | 1 | One-cycle pulse: a new frame begins, no data this cycle |
| rx_valid | input | 1 | rx_byte holds a frame byte |
| rx_byte | input | 8 | Received frame byte |
| crc_snap_valid | input | 1 | crc_snap holds the CRC after the last address byte |
| crc_snap | input | 32 | Running CRC register value |
| decide | output | 1 | One-cycle decision pulse |
| accept | output | 1 | Frame is kept (valid with decide) |
| match_type | output | 3 | 0 none, 1 unicast, 2 multicast, 3 broadcast, 4 promiscuous |

## Verification
The hardest case to reach is a broadcast frame accepted while broadcast enable is low. It needs the table bit chosen by the CRC snapshot to be set, multicast to be enabled, and all six bytes to be all-ones, all at the same time. The bench loads a single table byte so that exactly one index hits. It then sends the all-ones address with a snapshot whose top six bits equal that index, and repeats with a neighbouring index to see the rejection. Ordering cases need their own stimulus as well. These are a snapshot given after only three bytes, a second snapshot in the same frame, and a start pulse partway through an address.

// File: rtl/rxaf_pkg.sv
// Shared types for the receive destination address filter.
package rxaf_pkg;
    // Which acceptance rule produced the decision.
    typedef enum logic [2:0] {
        MT_NONE  = 3'd0,
        MT_UNI   = 3'd1,
        MT_MCAST = 3'd2,
        MT_BCAST = 3'd3,
        MT_PROM  = 3'd4
    } match_t;
endpackage

// File: rtl/rxaf_station_reg.sv
// Station address store.
// Holds ADDR_BYTES bytes written one at a time. Byte b is the b-th byte after
// the start of frame. Assumes the writer keeps wr_idx below ADDR_BYTES.
module rxaf_station_reg #(
    parameter int ADDR_BYTES = 6,
    localparam int IDX_W = $clog2(ADDR_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [7:0]              wr_data,
    output logic [8*ADDR_BYTES-1:0] sta
);
    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
        logic [7:0] q;
        // Load this byte when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(b)) begin
                q <= wr_data;
            end
        end
        assign sta[8*b +: 8] = q;
    end
endmodule

// File: rtl/rxaf_hash_table.sv
// Multicast hash table.
// 2**HASH_BITS single-bit entries, written a byte at a time and read by index.
// Assumes HASH_BITS >= 3, so that the table holds whole bytes.
module rxaf_hash_table #(
    parameter int HASH_BITS = 6,
    localparam int DEPTH  = 1 << HASH_BITS,
    localparam int NBYTES = DEPTH / 8,
    localparam int IDX_W  = $clog2(NBYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [7:0]           wr_data,
    input  logic [HASH_BITS-1:0] look_idx,
    output logic                 look_bit
);
    logic [DEPTH-1:0] tbl;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [7:0] q;
        // Load this table byte when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(b)) begin
                q <= wr_data;
            end
        end
        assign tbl[8*b +: 8] = q;
    end

    // Select the bit named by the hash index.
    assign look_bit = tbl[look_idx];
endmodule

// File: rtl/rxaf_addr_capture.sv
// Address byte tracker.
// It counts the first ADDR_BYTES bytes after a frame start. As each byte arrives
// it folds it into three flags: equal to the station address, all ones, and the
// group bit (bit 0 of the first byte). The address itself is not stored.
// Assumes frm_start carries no data byte. Reset leaves the tracker full, so
// nothing is taken until the first frame start.
module rxaf_addr_capture #(
    parameter int ADDR_BYTES = 6,
    localparam int CNT_W = $clog2(ADDR_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frm_start,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_byte,
    input  logic [8*ADDR_BYTES-1:0] sta,
    output logic                    addr_full,
    output logic                    uni_hit,
    output logic                    bc_hit,
    output logic                    mc_bit
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_BYTES);

    logic [CNT_W-1:0]      cnt_q;
    logic                  eq_q, ones_q, grp_q;
    logic [ADDR_BYTES-1:0] byte_eq;
    logic                  cur_eq;
    logic                  take;

    // Per-position comparison of the incoming byte with the station byte.
    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_cmp
        assign byte_eq[b] = (rx_byte == sta[8*b +: 8]);
    end

    // Pick the comparison that belongs to the current byte position.
    always_comb begin
        cur_eq = 1'b0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (cnt_q == CNT_W'(i)) cur_eq = byte_eq[i];
        end
    end

    assign take = rx_valid && (cnt_q != FULL);

    // Count address bytes and fold each one into the match flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= FULL;
            eq_q   <= 1'b0;
            ones_q <= 1'b0;
            grp_q  <= 1'b0;
        end else if (frm_start) begin
            cnt_q  <= '0;
            eq_q   <= 1'b1;
            ones_q <= 1'b1;
            grp_q  <= 1'b0;
        end else if (take) begin
            cnt_q  <= cnt_q + 1'b1;
            eq_q   <= eq_q & cur_eq;
            ones_q <= ones_q & (rx_byte == 8'hFF);
            if (cnt_q == '0) grp_q <= rx_byte[0];
        end
    end

    assign addr_full = (cnt_q == FULL);
    assign uni_hit   = eq_q;
    assign bc_hit    = ones_q;
    assign mc_bit    = grp_q;
endmodule

// File: rtl/rxaf_decide.sv
// Decision stage.
// It ranks the acceptance rules (unicast, broadcast, hashed multicast,
// promiscuous) and registers the result for one cycle. This happens the first
// time a CRC snapshot is seen after the address is complete, and once per frame.
// Assumes the snapshot's hash bit is already looked up (hash_bit).
module rxaf_decide
    import rxaf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frm_start,
    input  logic       snap_valid,
    input  logic       addr_full,
    input  logic       uni_hit,
    input  logic       bc_hit,
    input  logic       mc_bit,
    input  logic       hash_bit,
    input  logic       ctl_promisc,
    input  logic       ctl_mcast_en,
    input  logic       ctl_bcast_en,
    output logic       decide,
    output logic       accept,
    output logic [2:0] match_type
);
    match_t cls;
    logic   done_q;
    logic   fire;

    // Rank the rules; the first one that holds wins.
    always_comb begin
        if (uni_hit)
            cls = MT_UNI;
        else if (bc_hit && (ctl_bcast_en || (ctl_mcast_en && hash_bit)))
            cls = MT_BCAST;
        else if (mc_bit && ctl_mcast_en && hash_bit)
            cls = MT_MCAST;
        else if (ctl_promisc)
            cls = MT_PROM;
        else
            cls = MT_NONE;
    end

    assign fire = snap_valid && addr_full && !done_q && !frm_start;

    // Remember that this frame already has its decision.
    always_ff @(posedge clk) begin
        if (!rst_n)          done_q <= 1'b1;
        else if (frm_start)  done_q <= 1'b0;
        else if (fire)       done_q <= 1'b1;
    end

    // Register the one-cycle decision and its outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            decide     <= 1'b0;
            accept     <= 1'b0;
            match_type <= MT_NONE;
        end else begin
            decide     <= fire;
            accept     <= fire && (cls != MT_NONE);
            match_type <= fire ? cls : MT_NONE;
        end
    end
endmodule

// File: rtl/rx_addr_filter.sv
// Receive destination address filter (top).
// It combines the station address store, the hash table, the address tracker
// and the decision stage. The hash index is the top HASH_BITS bits of the CRC
// snapshot. Assumes the CRC snapshot strobe comes after the last address byte
// has been through the CRC unit.
module rx_addr_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    parameter int CRC_W      = 32
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    sta_wr_en,
    input  logic [$clog2(ADDR_BYTES)-1:0]           sta_wr_idx,
    input  logic [7:0]                              sta_wr_data,
    input  logic                                    tbl_wr_en,
    input  logic [$clog2((1 << HASH_BITS) / 8)-1:0] tbl_wr_idx,
    input  logic [7:0]                              tbl_wr_data,
    input  logic                                    ctl_promisc,
    input  logic                                    ctl_mcast_en,
    input  logic                                    ctl_bcast_en,
    input  logic                                    frm_start,
    input  logic                                    rx_valid,
    input  logic [7:0]                              rx_byte,
    input  logic                                    crc_snap_valid,
    input  logic [CRC_W-1:0]                        crc_snap,
    output logic                                    decide,
    output logic                                    accept,
    output logic [2:0]                              match_type
);
    logic [8*ADDR_BYTES-1:0] sta;
    logic [HASH_BITS-1:0]    hash_idx;
    logic                    hash_bit;
    logic                    addr_full, uni_hit, bc_hit, mc_bit;

    assign hash_idx = crc_snap[CRC_W-1 -: HASH_BITS];

    rxaf_station_reg #(.ADDR_BYTES(ADDR_BYTES)) u_sta (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sta_wr_en),
        .wr_idx  (sta_wr_idx),
        .wr_data (sta_wr_data),
        .sta     (sta)
    );

    rxaf_hash_table #(.HASH_BITS(HASH_BITS)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_en),
        .wr_idx   (tbl_wr_idx),
        .wr_data  (tbl_wr_data),
        .look_idx (hash_idx),
        .look_bit (hash_bit)
    );

    rxaf_addr_capture #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_start (frm_start),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .sta       (sta),
        .addr_full (addr_full),
        .uni_hit   (uni_hit),
        .bc_hit    (bc_hit),
        .mc_bit    (mc_bit)
    );

    rxaf_decide u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .frm_start    (frm_start),
        .snap_valid   (crc_snap_valid),
        .addr_full    (addr_full),
        .uni_hit      (uni_hit),
        .bc_hit       (bc_hit),
        .mc_bit       (mc_bit),
        .hash_bit     (hash_bit),
        .ctl_promisc  (ctl_promisc),
        .ctl_mcast_en (ctl_mcast_en),
        .ctl_bcast_en (ctl_bcast_en),
        .decide       (decide),
        .accept       (accept),
        .match_type   (match_type)
    );
endmodule

// File: rtl/rxaf_checker.sv
// Property checker for rx_addr_filter, attached by bind.
// It looks only at the top-level ports.
module rxaf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_promisc,
    input logic       ctl_mcast_en,
    input logic       ctl_bcast_en,
    input logic       frm_start,
    input logic       crc_snap_valid,
    input logic       decide,
    input logic       accept,
    input logic [2:0] match_type
);
    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decide |=> !decide);

    // R9
    decide_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decide |-> $past(crc_snap_valid));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !decide |-> (!accept && match_type == 3'd0));

    // R8
    accept_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decide |-> (accept == (match_type != 3'd0)));

    // R7
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && $past(ctl_promisc)) |-> accept);

    // R4
    mcast_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && match_type == 3'd2) |-> $past(ctl_mcast_en));

    // R5
    bcast_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && match_type == 3'd3) |-> $past(ctl_bcast_en || ctl_mcast_en));

    // R11
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start |=> !decide);
endmodule

bind rx_addr_filter rxaf_checker u_chk (.*);

// File: tb/rx_addr_filter_test.sv
`timescale 1ns/1ps
module rx_addr_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sta_wr_en = 1'b0;
    logic [2:0]  sta_wr_idx = '0;
    logic [7:0]  sta_wr_data = '0;
    logic        tbl_wr_en = 1'b0;
    logic [2:0]  tbl_wr_idx = '0;
    logic [7:0]  tbl_wr_data = '0;
    logic        ctl_promisc = 1'b0;
    logic        ctl_mcast_en = 1'b0;
    logic        ctl_bcast_en = 1'b0;
    logic        frm_start = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        crc_snap_valid = 1'b0;
    logic [31:0] crc_snap = '0;
    logic        decide, accept;
    logic [2:0]  match_type;

    int n_chk = 0;
    int n_bad = 0;
    logic [47:0] sta_sh = '0;
    logic [63:0] tbl_sh = '0;

    always #2.5 clk = ~clk;

    rx_addr_filter uut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected match code from the requirements, using bench shadow state.
    function automatic int model(input logic [47:0] da, input logic [31:0] crc);
        logic hb;
        hb = tbl_sh[crc[31:26]];
        if (da == sta_sh) return 1;
        if (da == 48'hFFFF_FFFF_FFFF && (ctl_bcast_en || (ctl_mcast_en && hb))) return 3;
        if (da[0] && ctl_mcast_en && hb) return 2;
        if (ctl_promisc) return 4;
        return 0;
    endfunction

    task automatic write_sta(input logic [47:0] v);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sta_wr_en = 1'b1; sta_wr_idx = 3'(i); sta_wr_data = v[8*i +: 8];
        end
        @(negedge clk); sta_wr_en = 1'b0;
        sta_sh = v;
    endtask

    task automatic write_tbl(input logic [63:0] v);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            tbl_wr_en = 1'b1; tbl_wr_idx = 3'(i); tbl_wr_data = v[8*i +: 8];
        end
        @(negedge clk); tbl_wr_en = 1'b0;
        tbl_sh = v;
    endtask

    task automatic begin_frame();
        @(negedge clk); frm_start = 1'b1;
        @(negedge clk); frm_start = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic send_addr(input logic [47:0] da, input int extra);
        begin_frame();
        for (int i = 0; i < 6; i++) put_byte(da[8*i +: 8]);
        for (int i = 0; i < extra; i++) put_byte(8'h3C ^ 8'(i));
    endtask

    // Give a snapshot; return the outputs in the cycle after it is taken.
    task automatic snap(input logic [31:0] crc, output logic d, output logic a,
                        output logic [2:0] m);
        @(negedge clk); crc_snap_valid = 1'b1; crc_snap = crc;
        @(negedge clk); crc_snap_valid = 1'b0;
        d = decide; a = accept; m = match_type;
    endtask

    task automatic frame_check(input string tag, input logic [47:0] da,
                               input logic [31:0] crc, input int extra);
        logic d, a;
        logic [2:0] m;
        int e;
        send_addr(da, extra);
        e = model(da, crc);
        snap(crc, d, a, m);
        chk({tag, " decide"}, int'(d), 1);
        chk({tag, " match"}, int'(m), e);
        chk({tag, " accept"}, int'(a), int'(e != 0));
        @(negedge clk);
        chk("R9 pulse ends", int'(decide), 0);
    endtask

    task automatic t_reset();
        chk("R11 reset decide", int'(decide), 0);
        chk("R11 reset accept", int'(accept), 0);
        chk("R11 reset match", int'(match_type), 0);
    endtask

    task automatic t_no_frame_yet();
        logic d, a;
        logic [2:0] m;
        put_byte(8'hFF);
        snap(32'h0, d, a, m);
        chk("R11 no decide before frame start", int'(d), 0);
    endtask

    task automatic t_unicast();
        write_sta(48'h6655_4433_2210);
        frame_check("R1 exact station", 48'h6655_4433_2210, 32'h1234_5678, 0);
        frame_check("R2 last byte differs", 48'h6755_4433_2210, 32'h1234_5678, 0);
        frame_check("R2 first byte differs", 48'h6655_4433_2212, 32'h1234_5678, 0);
    endtask

    task automatic t_multicast();
        write_tbl(64'h0000_0020_0000_0000);   // only bit 37
        ctl_mcast_en = 1'b1;
        frame_check("R3 R12 hash hit", 48'hCCBB_AA00_5E01, {6'd37, 26'h0ABCDEF}, 0);
        frame_check("R3 R12 hash miss", 48'hCCBB_AA00_5E01, {6'd36, 26'h0ABCDEF}, 0);
        frame_check("R3 group bit clear", 48'hCCBB_AA00_5E00, {6'd37, 26'h0}, 0);
        ctl_mcast_en = 1'b0;
        frame_check("R4 multicast disabled", 48'hCCBB_AA00_5E01, {6'd37, 26'h0ABCDEF}, 0);
    endtask

    task automatic t_broadcast();
        ctl_bcast_en = 1'b1;
        frame_check("R5 broadcast enabled", 48'hFFFF_FFFF_FFFF, {6'd2, 26'h0}, 0);
        ctl_bcast_en = 1'b0;
        ctl_mcast_en = 1'b1;
        frame_check("R6 broadcast via hash", 48'hFFFF_FFFF_FFFF, {6'd37, 26'h155}, 0);
        frame_check("R6 broadcast hash miss", 48'hFFFF_FFFF_FFFF, {6'd38, 26'h155}, 0);
        ctl_mcast_en = 1'b0;
    endtask

    task automatic t_promisc();
        ctl_promisc = 1'b1;
        frame_check("R7 unknown address", 48'h0102_0304_0506, 32'h0, 0);
        frame_check("R8 unicast over promisc", 48'h6655_4433_2210, 32'h0, 0);
        ctl_bcast_en = 1'b1;
        frame_check("R8 broadcast over promisc", 48'hFFFF_FFFF_FFFF, 32'h0, 0);
        ctl_bcast_en = 1'b0;
        ctl_mcast_en = 1'b1;
        frame_check("R8 multicast over promisc", 48'hCCBB_AA00_5E01, {6'd37, 26'h0}, 0);
        ctl_mcast_en = 1'b0;
        ctl_promisc = 1'b0;
    endtask

    task automatic t_ordering();
        logic d, a;
        logic [2:0] m;
        frame_check("R10 trailing bytes ignored", 48'h6655_4433_2210, 32'h0, 4);
        begin_frame();
        put_byte(8'h10); put_byte(8'h22); put_byte(8'h33);
        snap(32'h0, d, a, m);
        chk("R10 early snapshot ignored", int'(d), 0);
        put_byte(8'h44); put_byte(8'h55); put_byte(8'h66);
        snap(32'h0, d, a, m);
        chk("R10 decide after sixth byte", int'(d), 1);
        chk("R10 unicast after early snap", int'(m), 1);
        snap(32'h0, d, a, m);
        chk("R9 second snapshot no decide", int'(d), 0);
        begin_frame();
        put_byte(8'hFF); put_byte(8'hFF); put_byte(8'h00);
        send_addr(48'h6655_4433_2210, 0);
        snap(32'h0, d, a, m);
        chk("R11 restart decide", int'(d), 1);
        chk("R11 restart match", int'(m), 1);
    endtask

    task automatic t_mixed();
        logic [47:0] da;
        logic [31:0] crc;
        write_tbl(64'hA5C3_0F96_1E2D_78B4);
        for (int i = 0; i < 16; i++) begin
            crc = 32'(i) * 32'h9E37_79B9 + 32'h0101_0101;
            da = {crc[15:0], crc, 8'(i * 37)} ^ 48'(i);
            if (i % 5 == 0) da = 48'hFFFF_FFFF_FFFF;
            ctl_mcast_en = (i % 3) != 0;
            ctl_promisc  = (i % 4) == 3;
            ctl_bcast_en = (i % 7) == 2;
            frame_check("R3 R8 mixed", da, crc, i % 3);
        end
        ctl_mcast_en = 1'b0; ctl_promisc = 1'b0; ctl_bcast_en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_frame_yet();
        t_unicast();
        t_multicast();
        t_broadcast();
        t_promisc();
        t_ordering();
        t_mixed();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule